// File: doc/BRIEF.md
# MESI Snooping Cache-Line State Controller

This block holds the tag and coherence state of every line of a small direct-mapped, write-back private cache attached to a shared snooping bus. It follows the four-state Illinois scheme. Each line is Modified, Exclusive, Shared or Invalid. A read fill lands in Exclusive or Shared according to a wired-OR presence vector that the other caches drive while the read is on the bus. A snooped read that finds a clean or dirty copy is answered cache-to-cache.

The processor side takes requests over a valid/ready handshake. The request is accepted on a clock edge where both `cpu_req_valid` and `cpu_req_ready` are high. The requester must hold address and direction steady until that edge. Exactly one response pulse follows each accepted request. The response cannot be back-pressured.

When the processor side needs the bus, the block raises `bus_req` and waits for `bus_gnt`. In the grant cycle it drives one command and samples the presence vector. The snoop side watches commands from other caches. In the same cycle it drives its own presence bit and a flush indication. The data array, memory and bus arbitration are outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_req_ready` is high, and `cpu_resp_valid`, `bus_req`, `bus_cmd_valid`, `flush_valid` and every bit of `shared_vec_out` are low.
- R2: A read that misses issues a read command (`bus_cmd` = 1) for the request address. The line fills Exclusive when no bit of `shared_vec_in` other than bit `cache_id` is set in the grant cycle, and Shared otherwise. The response has `cpu_resp_hit` = 0.
- R3: A write to an Invalid or Shared line issues a read-exclusive command (`bus_cmd` = 2) and leaves the line Modified. The response has `cpu_resp_hit` = 0.
- R4: A read to any valid line, and a write to a Modified or Exclusive line, use no bus command. The response has `cpu_resp_hit` = 1 in the cycle after acceptance. A write to Exclusive makes the line Modified.
- R5: A snooped read (`snp_cmd` = 1) that hits a valid line sets bit `cache_id` of `shared_vec_out`. On a Modified line it raises `flush_valid` with `flush_dirty` = 1. On an Exclusive line it raises `flush_valid` with `flush_dirty` = 0. In both cases the line becomes Shared.
- R6: A snooped read-exclusive (`snp_cmd` = 2) that hits a valid line sets bit `cache_id` of `shared_vec_out` and makes the line Invalid. A Modified line flushes with `flush_dirty` = 1. An Exclusive line flushes with `flush_dirty` = 0.
- R7: A Shared line hit by a snooped read or read-exclusive flushes, with `flush_dirty` = 0, only when no bit of `shared_vec_in` below `cache_id` is set. Otherwise it takes no data action.
- R8: A miss whose index holds a Modified line with another tag first issues a writeback (`bus_cmd` = 3) with the victim address. It then needs a second grant for the fill. A clean victim is dropped with no command.
- R9: A snoop whose `snp_src` equals `cache_id`, a snooped writeback, or a snoop whose tag misses has no effect. Presence and flush stay low and the line state is unchanged.
- R10: No request is accepted in a cycle with `snp_valid` high. `bus_req` stays high until a grant. The command is chosen from the line state in the grant cycle, so a victim lost to a snoop while waiting causes no writeback.
- R11: Each accepted request gives exactly one single-cycle `cpu_resp_valid` pulse. `cpu_req_ready` is low from acceptance of a miss until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_id | input | ID_W | Strapped identity of this cache, also its supplier priority (lower wins) |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_hit | output | 1 | Completed without a bus command |
| bus_req | output | 1 | Bus wanted |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd_valid | output | 1 | Command driven this cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 writeback |
| bus_addr | output | ADDR_W | Line address of the command |
| snp_valid | input | 1 | Another agent's command is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_src | input | ID_W | Identity of the issuing cache |
| shared_vec_in | input | N_CACHES | Wired-OR presence vector, bit i driven by cache i |
| shared_vec_out | output | N_CACHES | This cache's contribution to the presence vector |
| flush_valid | output | 1 | This cache supplies the snooped line now |
| flush_dirty | output | 1 | The supplied line was Modified |

## Verification
The processor path is tried with reads and writes against lines in each of the four states. This separates silent hits, upgrades and fills. Fills are run with an empty presence vector, with another cache's bit and with only this cache's own bit set, which separates Exclusive from Shared fills and shows that the own bit is masked. Snoops are run against each state with presence vectors that hold lower, higher or no other sharers, which checks the supplier choice. Conflicting addresses, a delayed grant with an intervening snoop, and snoops from the cache's own identity check eviction ordering, the re-evaluation at grant time and the ignore cases.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/mesi_tag_store.sv
`timescale 1ns/1ps
module mesi_tag_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  // read port for the processor side
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output line_st_t         ra_st,
  // read port for the snoop side
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output line_st_t         rb_st,
  // snoop-side state update
  input  logic             sw_en,
  input  logic [IDX_W-1:0] sw_idx,
  input  line_st_t         sw_st,
  // processor-side update, wins on the same index
  input  logic             rw_en,
  input  logic [IDX_W-1:0] rw_idx,
  input  logic [TAG_W-1:0] rw_tag,
  input  line_st_t         rw_st
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0][1:0]       st_vec;
  logic [LINES-1:0][TAG_W-1:0] tag_vec;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]       st_r;
    logic [TAG_W-1:0] tag_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_r  <= ST_I;
        tag_r <= '0;
      end else if (rw_en && rw_idx == IDX_W'(g)) begin
        st_r  <= rw_st;
        tag_r <= rw_tag;
      end else if (sw_en && sw_idx == IDX_W'(g)) begin
        st_r  <= sw_st;
      end
    end
    assign st_vec[g]  = st_r;
    assign tag_vec[g] = tag_r;
  end

  assign ra_st  = line_st_t'(st_vec[ra_idx]);
  assign ra_tag = tag_vec[ra_idx];
  assign rb_st  = line_st_t'(st_vec[rb_idx]);
  assign rb_tag = tag_vec[rb_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
`timescale 1ns/1ps
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int ID_W     = 2,
  parameter int TAG_W    = 7
) (
  input  logic                snp_valid,
  input  logic [1:0]          snp_cmd,
  input  logic [ID_W-1:0]     snp_src,
  input  logic [TAG_W-1:0]    snp_tag,
  input  logic [ID_W-1:0]     cache_id,
  input  logic [TAG_W-1:0]    line_tag,
  input  line_st_t            line_st,
  input  logic [N_CACHES-1:0] shared_vec_in,
  output logic                present,
  output logic                flush,
  output logic                flush_dirty,
  output logic                upd_en,
  output line_st_t            upd_st
);
  logic [N_CACHES-1:0] lower_mask;
  logic                supplier;
  logic                hit;
  logic                rd_like;

  always_comb begin
    for (int i = 0; i < N_CACHES; i++) begin
      lower_mask[i] = (i < int'(cache_id));
    end
  end

  // lowest identity among the holders of a clean shared copy supplies it
  assign supplier = ((shared_vec_in & lower_mask) == '0);
  assign rd_like  = (snp_cmd == CMD_RD) || (snp_cmd == CMD_RDX);
  assign hit      = snp_valid && (snp_src != cache_id) && rd_like &&
                    (line_st != ST_I) && (line_tag == snp_tag);

  always_comb begin
    present     = hit;
    flush       = 1'b0;
    flush_dirty = 1'b0;
    upd_en      = hit;
    upd_st      = (snp_cmd == CMD_RDX) ? ST_I : ST_S;
    if (hit) begin
      unique case (line_st)
        ST_M: begin
          flush       = 1'b1;
          flush_dirty = 1'b1;
        end
        ST_E:    flush = 1'b1;
        ST_S:    flush = supplier;
        default: flush = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mesi_req_ctrl.sv
`timescale 1ns/1ps
module mesi_req_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_resp_valid,
  output logic              cpu_resp_hit,
  input  logic              snp_valid,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_st_t          line_st,
  output logic              rw_en,
  output logic [IDX_W-1:0]  rw_idx,
  output logic [TAG_W-1:0]  rw_tag,
  output line_st_t          rw_st,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output bus_cmd_t          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              shared_any
);
  typedef enum logic {RQ_IDLE = 1'b0, RQ_BUS = 1'b1} rq_state_t;

  rq_state_t         fsm_q, fsm_d;
  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic              wr_q, cur_wr;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              tag_hit, accept, done, done_hit;
  logic              resp_v_q, resp_hit_q;

  always_comb begin
    cur_addr      = (fsm_q == RQ_IDLE) ? cpu_req_addr : addr_q;
    cur_wr        = (fsm_q == RQ_IDLE) ? cpu_req_write : wr_q;
    cur_idx       = cur_addr[IDX_W-1:0];
    cur_tag       = cur_addr[ADDR_W-1:IDX_W];
    tag_hit       = (line_st != ST_I) && (line_tag == cur_tag);
    cpu_req_ready = (fsm_q == RQ_IDLE) && !snp_valid;
    accept        = cpu_req_ready && cpu_req_valid;
    rd_idx        = cur_idx;
    rw_idx        = cur_idx;
    rw_en         = 1'b0;
    rw_tag        = line_tag;
    rw_st         = line_st;
    fsm_d         = fsm_q;
    bus_req       = (fsm_q == RQ_BUS);
    bus_cmd_valid = 1'b0;
    bus_cmd       = CMD_NONE;
    bus_addr      = cur_addr;
    done          = 1'b0;
    done_hit      = 1'b0;
    if (accept) begin
      if (tag_hit && (!cur_wr || line_st == ST_M || line_st == ST_E)) begin
        done     = 1'b1;
        done_hit = 1'b1;
        if (cur_wr) begin
          rw_en = 1'b1;
          rw_st = ST_M;
        end
      end else begin
        fsm_d = RQ_BUS;
      end
    end else if (fsm_q == RQ_BUS && bus_gnt) begin
      bus_cmd_valid = 1'b1;
      if (line_st == ST_M && !tag_hit) begin
        // dirty victim leaves first, the fill needs another grant
        bus_cmd  = CMD_WB;
        bus_addr = {line_tag, cur_idx};
        rw_en    = 1'b1;
        rw_st    = ST_I;
      end else begin
        bus_cmd = cur_wr ? CMD_RDX : CMD_RD;
        rw_en   = 1'b1;
        rw_tag  = cur_tag;
        rw_st   = cur_wr ? ST_M : (shared_any ? ST_S : ST_E);
        done    = 1'b1;
        fsm_d   = RQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q      <= RQ_IDLE;
      addr_q     <= '0;
      wr_q       <= 1'b0;
      resp_v_q   <= 1'b0;
      resp_hit_q <= 1'b0;
    end else begin
      fsm_q      <= fsm_d;
      resp_v_q   <= done;
      resp_hit_q <= done_hit;
      if (accept) begin
        addr_q <= cpu_req_addr;
        wr_q   <= cpu_req_write;
      end
    end
  end

  assign cpu_resp_valid = resp_v_q;
  assign cpu_resp_hit   = resp_hit_q;

  assert_breq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  assert_miss_follows_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_resp_valid && !cpu_resp_hit) |-> ($past(bus_cmd_valid) && $past(bus_cmd) != CMD_WB));

  assert_wb_then_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && bus_cmd == CMD_WB) |=> (bus_req && !cpu_resp_valid));

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_req_ready);
endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int ADDR_W   = 10,
  parameter int IDX_W    = 3,
  localparam int ID_W    = $clog2(N_CACHES),
  localparam int TAG_W   = ADDR_W - IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ID_W-1:0]     cache_id,
  input  logic                cpu_req_valid,
  output logic                cpu_req_ready,
  input  logic                cpu_req_write,
  input  logic [ADDR_W-1:0]   cpu_req_addr,
  output logic                cpu_resp_valid,
  output logic                cpu_resp_hit,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                bus_cmd_valid,
  output logic [1:0]          bus_cmd,
  output logic [ADDR_W-1:0]   bus_addr,
  input  logic                snp_valid,
  input  logic [1:0]          snp_cmd,
  input  logic [ADDR_W-1:0]   snp_addr,
  input  logic [ID_W-1:0]     snp_src,
  input  logic [N_CACHES-1:0] shared_vec_in,
  output logic [N_CACHES-1:0] shared_vec_out,
  output logic                flush_valid,
  output logic                flush_dirty
);
  logic [N_CACHES-1:0] own_bit;
  logic                shared_any;
  logic [IDX_W-1:0]    ra_idx, rw_idx;
  logic [TAG_W-1:0]    ra_tag, rb_tag, rw_tag;
  line_st_t            ra_st, rb_st, rw_st, sw_st;
  logic                rw_en, sw_en, present;
  bus_cmd_t            cmd_int;

  assign own_bit    = {{(N_CACHES-1){1'b0}}, 1'b1} << cache_id;
  assign shared_any = |(shared_vec_in & ~own_bit);

  mesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_idx (ra_idx),
    .ra_tag (ra_tag),
    .ra_st  (ra_st),
    .rb_idx (snp_addr[IDX_W-1:0]),
    .rb_tag (rb_tag),
    .rb_st  (rb_st),
    .sw_en  (sw_en),
    .sw_idx (snp_addr[IDX_W-1:0]),
    .sw_st  (sw_st),
    .rw_en  (rw_en),
    .rw_idx (rw_idx),
    .rw_tag (rw_tag),
    .rw_st  (rw_st)
  );

  mesi_snoop_unit #(.N_CACHES(N_CACHES), .ID_W(ID_W), .TAG_W(TAG_W)) u_snoop (
    .snp_valid     (snp_valid),
    .snp_cmd       (snp_cmd),
    .snp_src       (snp_src),
    .snp_tag       (snp_addr[ADDR_W-1:IDX_W]),
    .cache_id      (cache_id),
    .line_tag      (rb_tag),
    .line_st       (rb_st),
    .shared_vec_in (shared_vec_in),
    .present       (present),
    .flush         (flush_valid),
    .flush_dirty   (flush_dirty),
    .upd_en        (sw_en),
    .upd_st        (sw_st)
  );

  mesi_req_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_req (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_req_write  (cpu_req_write),
    .cpu_req_addr   (cpu_req_addr),
    .cpu_resp_valid (cpu_resp_valid),
    .cpu_resp_hit   (cpu_resp_hit),
    .snp_valid      (snp_valid),
    .rd_idx         (ra_idx),
    .line_tag       (ra_tag),
    .line_st        (ra_st),
    .rw_en          (rw_en),
    .rw_idx         (rw_idx),
    .rw_tag         (rw_tag),
    .rw_st          (rw_st),
    .bus_req        (bus_req),
    .bus_gnt        (bus_gnt),
    .bus_cmd_valid  (bus_cmd_valid),
    .bus_cmd        (cmd_int),
    .bus_addr       (bus_addr),
    .shared_any     (shared_any)
  );

  assign bus_cmd        = cmd_int;
  assign shared_vec_out = present ? own_bit : '0;

  assert_flush_has_presence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (shared_vec_out == own_bit));

  assert_hit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_resp_valid && cpu_resp_hit) |-> !$past(bus_cmd_valid));

  assert_presence_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(shared_vec_out));
endmodule

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;
  localparam int N  = 4;
  localparam int AW = 10;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cache_id = 2'd1;
  logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic          cpu_req_ready, cpu_resp_valid, cpu_resp_hit;
  logic          bus_req, bus_cmd_valid;
  logic          bus_gnt = 1'b0;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [1:0]    snp_src = '0;
  logic [N-1:0]  shared_vec_in = '0;
  logic [N-1:0]  shared_vec_out;
  logic          flush_valid, flush_dirty;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.N_CACHES(N), .ADDR_W(AW), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .cache_id(cache_id),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_src(snp_src),
    .shared_vec_in(shared_vec_in), .shared_vec_out(shared_vec_out),
    .flush_valid(flush_valid), .flush_dirty(flush_dirty)
  );

  localparam logic [AW-1:0] A = 10'h012, B = 10'h022, C = 10'h035, D = 10'h045;

  typedef struct packed {
    logic          snp;    // 0 processor op, 1 snoop
    logic [1:0]    op;     // cpu: 0 read 1 write; snoop: command
    logic [AW-1:0] addr;
    logic [1:0]    src;
    logic [N-1:0]  sh;
    logic [3:0]    req;
    logic          e_hit;
    logic [1:0]    e_c1;
    logic [AW-1:0] e_a1;
    logic [1:0]    e_c2;
    logic [N-1:0]  e_sh;
    logic          e_fl;
    logic          e_d;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd0, A, 2'd0, 4'b0000, 4'd2,  1'b0, 2'd1, A, 2'd0, 4'b0000, 1'b0, 1'b0}, // R2 fill E
    '{1'b0, 2'd1, A, 2'd0, 4'b0000, 4'd4,  1'b1, 2'd0, A, 2'd0, 4'b0000, 1'b0, 1'b0}, // R4 E->M silent
    '{1'b0, 2'd0, A, 2'd0, 4'b0000, 4'd4,  1'b1, 2'd0, A, 2'd0, 4'b0000, 1'b0, 1'b0}, // R4 read M
    '{1'b1, 2'd1, A, 2'd2, 4'b0000, 4'd5,  1'b0, 2'd0, A, 2'd0, 4'b0010, 1'b1, 1'b1}, // R5 M flush
    '{1'b0, 2'd0, A, 2'd0, 4'b0000, 4'd4,  1'b1, 2'd0, A, 2'd0, 4'b0000, 1'b0, 1'b0}, // R4 read S
    '{1'b0, 2'd1, A, 2'd0, 4'b0000, 4'd3,  1'b0, 2'd2, A, 2'd0, 4'b0000, 1'b0, 1'b0}, // R3 S upgrade
    '{1'b1, 2'd2, A, 2'd0, 4'b0000, 4'd6,  1'b0, 2'd0, A, 2'd0, 4'b0010, 1'b1, 1'b1}, // R6 M flush inval
    '{1'b0, 2'd0, A, 2'd0, 4'b0100, 4'd2,  1'b0, 2'd1, A, 2'd0, 4'b0000, 1'b0, 1'b0}, // R2 fill S
    '{1'b1, 2'd1, A, 2'd3, 4'b0001, 4'd7,  1'b0, 2'd0, A, 2'd0, 4'b0010, 1'b0, 1'b0}, // R7 lower sharer
    '{1'b1, 2'd1, A, 2'd3, 4'b0100, 4'd7,  1'b0, 2'd0, A, 2'd0, 4'b0010, 1'b1, 1'b0}, // R7 supplier
    '{1'b1, 2'd2, A, 2'd0, 4'b0000, 4'd7,  1'b0, 2'd0, A, 2'd0, 4'b0010, 1'b1, 1'b0}, // R7 rdx supplier
    '{1'b0, 2'd0, A, 2'd0, 4'b0000, 4'd2,  1'b0, 2'd1, A, 2'd0, 4'b0000, 1'b0, 1'b0}, // R2 refill E
    '{1'b1, 2'd2, A, 2'd2, 4'b0001, 4'd6,  1'b0, 2'd0, A, 2'd0, 4'b0010, 1'b1, 1'b0}, // R6 E flush inval
    '{1'b0, 2'd1, A, 2'd0, 4'b0000, 4'd3,  1'b0, 2'd2, A, 2'd0, 4'b0000, 1'b0, 1'b0}, // R3 I write
    '{1'b0, 2'd0, B, 2'd0, 4'b0000, 4'd8,  1'b0, 2'd3, A, 2'd1, 4'b0000, 1'b0, 1'b0}, // R8 dirty victim
    '{1'b1, 2'd1, A, 2'd0, 4'b0000, 4'd9,  1'b0, 2'd0, A, 2'd0, 4'b0000, 1'b0, 1'b0}, // R9 tag miss
    '{1'b0, 2'd0, C, 2'd0, 4'b0010, 4'd2,  1'b0, 2'd1, C, 2'd0, 4'b0000, 1'b0, 1'b0}, // R2 own bit masked
    '{1'b0, 2'd1, C, 2'd0, 4'b0000, 4'd4,  1'b1, 2'd0, C, 2'd0, 4'b0000, 1'b0, 1'b0}, // R4 proves E
    '{1'b1, 2'd1, C, 2'd1, 4'b0000, 4'd9,  1'b0, 2'd0, C, 2'd0, 4'b0000, 1'b0, 1'b0}, // R9 own source
    '{1'b1, 2'd3, C, 2'd2, 4'b0000, 4'd9,  1'b0, 2'd0, C, 2'd0, 4'b0000, 1'b0, 1'b0}, // R9 snooped wb
    '{1'b1, 2'd1, C, 2'd2, 4'b0000, 4'd5,  1'b0, 2'd0, C, 2'd0, 4'b0010, 1'b1, 1'b1}, // R5 still M
    '{1'b0, 2'd0, A, 2'd0, 4'b0000, 4'd8,  1'b0, 2'd1, A, 2'd0, 4'b0000, 1'b0, 1'b0}, // R8 clean victim
    '{1'b0, 2'd0, B, 2'd0, 4'b0000, 4'd8,  1'b0, 2'd1, B, 2'd0, 4'b0000, 1'b0, 1'b0}  // R8 clean victim
  };

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  task automatic run_cpu(input logic wr, input logic [AW-1:0] a, input logic [N-1:0] sh,
                         output logic hit, output logic [1:0] c1,
                         output logic [AW-1:0] a1, output logic [1:0] c2);
    int n = 0;
    hit = 1'b0; c1 = 2'd0; a1 = '0; c2 = 2'd0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
    while (!cpu_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    for (int g = 0; g < 4 && !cpu_resp_valid; g++) begin
      bus_gnt = 1'b1; shared_vec_in = sh;
      #1;
      if (bus_cmd_valid) begin
        if (n == 0) begin c1 = bus_cmd; a1 = bus_addr; end
        else c2 = bus_cmd;
        n++;
      end
      @(posedge clk);
      @(negedge clk);
      bus_gnt = 1'b0; shared_vec_in = '0;
    end
    hit = cpu_resp_valid && cpu_resp_hit;
  endtask

  task automatic run_snp(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [1:0] src,
                         input logic [N-1:0] sh, output logic [N-1:0] sho,
                         output logic fl, output logic d);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a; snp_src = src; shared_vec_in = sh;
    #1;
    sho = shared_vec_out; fl = flush_valid; d = flush_dirty;
    @(posedge clk);
    #1;
    snp_valid = 1'b0; shared_vec_in = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic          hit;
    logic [1:0]    c1, c2;
    logic [AW-1:0] a1;
    logic [N-1:0]  sho;
    logic          fl, d;
    string         rq;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ready", cpu_req_ready, 1);
    check("R1", "resp", cpu_resp_valid, 0);
    check("R1", "bus_req", bus_req, 0);
    check("R1", "cmd_valid", bus_cmd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_snp(2'd1, A, 2'd2, 4'b0000, sho, fl, d);
    check("R1", "presence on empty", sho, 0);
    check("R1", "flush on empty", fl, 0);

    for (int i = 0; i < NV; i++) begin
      rq = $sformatf("R%0d vec%0d", TBL[i].req, i);
      if (!TBL[i].snp) begin
        run_cpu(TBL[i].op[0], TBL[i].addr, TBL[i].sh, hit, c1, a1, c2);
        check(rq, "hit", hit, TBL[i].e_hit);
        check(rq, "cmd1", c1, TBL[i].e_c1);
        if (TBL[i].e_c1 != 2'd0) check(rq, "addr1", a1, TBL[i].e_a1);
        check(rq, "cmd2", c2, TBL[i].e_c2);
      end else begin
        run_snp(TBL[i].op, TBL[i].addr, TBL[i].src, TBL[i].sh, sho, fl, d);
        check(rq, "presence", sho, TBL[i].e_sh);
        check(rq, "flush", fl, TBL[i].e_fl);
        check(rq, "dirty", d, TBL[i].e_d);
      end
    end

    // R11: response is a single pulse
    @(negedge clk);
    check("R11", "resp pulse width", cpu_resp_valid, 0);

    // R10: a snoop blocks acceptance
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = A;
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = D; snp_src = 2'd2;
    #1;
    check("R10", "ready during snoop", cpu_req_ready, 0);
    @(posedge clk);
    #1;
    snp_valid = 1'b0; cpu_req_valid = 1'b0;
    @(negedge clk);
    check("R10", "no response after blocked cycle", cpu_resp_valid, 0);
    check("R10", "no bus request after blocked cycle", bus_req, 0);

    // R3: upgrade C from Shared
    run_cpu(1'b1, C, 4'b0000, hit, c1, a1, c2);
    check("R3", "upgrade cmd", c1, 2);
    check("R3", "upgrade hit", hit, 0);

    // R10: wait for grant, victim C stolen meanwhile, so no writeback
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = D;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    check("R11", "ready low while busy", cpu_req_ready, 0);
    for (int k = 0; k < 2; k++) begin
      check("R10", "bus_req held", bus_req, 1);
      check("R10", "no early response", cpu_resp_valid, 0);
      @(negedge clk);
    end
    snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = C; snp_src = 2'd0;
    #1;
    check("R6", "steal flush", flush_valid, 1);
    check("R6", "steal dirty", flush_dirty, 1);
    @(posedge clk);
    #1;
    snp_valid = 1'b0;
    @(negedge clk);
    bus_gnt = 1'b1;
    #1;
    check("R10", "cmd at grant", bus_cmd, 1);
    check("R10", "addr at grant", bus_addr, D);
    @(posedge clk);
    @(negedge clk);
    bus_gnt = 1'b0;
    check("R10", "resp after fill", cpu_resp_valid, 1);
    check("R10", "resp miss", cpu_resp_hit, 0);

    @(negedge clk);
    summary();
    $finish;
  end
endmodule